// File: doc/BRIEF.md
# SPI Master Serial Clock and Frame Timing Generator

This block produces the serial clock, the chip-select enable window and the bit index for an SPI master. It runs from the system clock. A one-cycle `start` pulse in the idle state samples the configuration inputs. These are:

- a baud prescaler code and a baud scaler code;
- a double-rate bit and the clock phase;
- a delay prescaler and scaler code;
- a frame-length code;
- a back-to-back mode with its override.

The block then plays out a whole frame, holds the chip select off for the trailing delay, and signals `done`.

The SCK period is a product of the prescaler and scaler values, halved when double rate is set. With double rate and an odd prescaler the two SCK levels have unequal lengths, and clock phase decides which level gets the longer share. The shift data path, FIFOs and register access live outside this block. They use `pcs_en`, `sck` and `bit_idx` to move data.

Top module: `spi_sck_timer`

## Requirements
- R1: After reset, and whenever no frame is active, `sck`, `pcs_en`, `busy`, `done` and `bit_idx` are all 0.
- R2: A `start` pulse seen at a rising edge while idle makes `pcs_en` and `busy` high from the next cycle on.
- R3: The prescaler code 0/1/2/3 selects the value P = 2/3/5/7. The scaler code c selects S = 2·(c+1) for c < 4 and S = 2^c for c ≥ 4. The SCK period is T = P·S/(1+dbl_rate) system clock cycles.
- R4: With `dbl_rate` = 0, each bit is T/2 cycles at one level followed by T/2 cycles at the other.
- R5: With `dbl_rate` = 1 and `cpha` = 0, each bit starts low for T − ⌊P/2⌋·S/2 cycles and then goes high for ⌊P/2⌋·S/2 cycles.
- R6: With `cpha` = 1, each bit starts high and ends low, and the segment lengths of R4/R5 stay in the same order. With `dbl_rate` = 1 this gives a high share of T − ⌊P/2⌋·S/2 cycles.
- R7: Frame-length code n in 3..15 gives n+1 bits, and codes 0..2 give 4 bits. `pcs_en` stays high for exactly N·T cycles. `bit_idx` steps from 0 to N−1, advancing every T cycles.
- R8: When `pcs_en` falls, the block waits D−1 cycles with `pcs_en` low and then raises `done` for exactly one cycle, with `busy` low. Here D = Pd·Sd, where the delay prescaler code 0/1/2/3 gives Pd = 1/3/5/7 and the delay scaler code m gives Sd = 2^(m+1).
- R9: With `cont_mode` = 1 and `cont_ovr` = 0, D equals the SCK period T. With `cont_ovr` = 1, D follows R8.
- R10: A `start` in the `done` cycle is accepted, so the gap between frames is exactly D low cycles of `pcs_en`. A `start` while `busy` is high has no effect on the running frame.
- R11: Configuration is sampled only at an accepted `start`. Changes during a frame do not alter its SCK waveform, length or trailing delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| baud_pre | input | 2 | Baud prescaler code |
| baud_scl | input | 4 | Baud scaler code |
| dbl_rate | input | 1 | Double baud rate |
| cpha | input | 1 | Clock phase |
| dly_pre | input | 2 | Trailing-delay prescaler code |
| dly_scl | input | 4 | Trailing-delay scaler code |
| frame_code | input | 4 | Frame length code |
| cont_mode | input | 1 | Back-to-back mode: gap equals one SCK period |
| cont_ovr | input | 1 | In back-to-back mode, use the programmed delay instead |
| sck | output | 1 | Serial clock |
| pcs_en | output | 1 | Chip-select enable, high during a frame |
| bit_idx | output | BIT_W | Index of the current bit in the frame |
| busy | output | 1 | Frame or trailing delay in progress |
| done | output | 1 | One-cycle pulse at the end of the trailing delay |

## Verification
The hardest situation to reach is a frame that starts in the very cycle `done` is high. Only then is the inter-frame gap exactly D cycles, and an off-by-one in the delay counter shows up only there. The bench therefore issues the next `start` at the `done` sample for most frames and counts the low cycles of `pcs_en`. Frames are run with random codes, and during some of them the configuration is scrambled and a stray `start` is injected. Directed sweeps cover every prescaler value under both phases and both rates, the reserved frame codes, and back-to-back mode with and without the override.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BIT  = 2'd1,
      ST_GAP  = 2'd2
   } tm_state_t;

   // baud prescaler code -> divide value
   function automatic logic [2:0] pre_fn(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd2;
         2'd1:    return 3'd3;
         2'd2:    return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   // delay prescaler code -> 1,3,5,7
   function automatic logic [2:0] dly_pre_fn(input logic [1:0] code);
      return {code, 1'b1};
   endfunction

   // baud scaler code -> 2,4,6,8 then powers of two
   function automatic int unsigned scl_fn(input int unsigned c);
      return (c < 4) ? 2 * (c + 1) : (32'd1 << c);
   endfunction

endpackage

// File: rtl/spi_tm_baud.sv
module spi_tm_baud
   import spi_tm_pkg::*;
#(
   parameter int CNT_W = 20,
   parameter int SCL_W = 4
) (
   input  logic [1:0]       baud_pre,
   input  logic [SCL_W-1:0] baud_scl,
   input  logic             dbl_rate,
   output logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] len_long,
   output logic [CNT_W-1:0] len_short
);
   localparam int SCL_N  = 2 ** SCL_W;
   localparam int SCL_VW = 2 ** SCL_W;

   logic [SCL_VW-1:0] scl_tab [SCL_N];

   for (genvar i = 0; i < SCL_N; i++) begin : g_scl
      assign scl_tab[i] = SCL_VW'(scl_fn(i));
   end

   logic [CNT_W-1:0] pv, sv, hv, short_v;

   always_comb begin
      pv      = CNT_W'(pre_fn(baud_pre));
      sv      = CNT_W'(scl_tab[baud_scl]);
      hv      = sv >> 1;
      period  = dbl_rate ? pv * hv : pv * sv;
      short_v = dbl_rate ? (pv >> 1) * hv : pv * hv;
      len_short = short_v;
      len_long  = period - short_v;
   end

endmodule

// File: rtl/spi_tm_gap.sv
module spi_tm_gap
   import spi_tm_pkg::*;
#(
   parameter int CNT_W = 20,
   parameter int DLY_W = 4
) (
   input  logic [1:0]       dly_pre,
   input  logic [DLY_W-1:0] dly_scl,
   input  logic             cont_mode,
   input  logic             cont_ovr,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] gap_len
);
   localparam int SH_W = DLY_W + 1;

   logic [CNT_W-1:0] pd, ds;
   logic [SH_W-1:0]  sh;

   always_comb begin
      sh      = {1'b0, dly_scl} + SH_W'(1);
      pd      = CNT_W'(dly_pre_fn(dly_pre));
      ds      = CNT_W'(1) << sh;
      gap_len = (cont_mode && !cont_ovr) ? period : pd * ds;
   end

endmodule

// File: rtl/spi_tm_seq.sv
module spi_tm_seq
   import spi_tm_pkg::*;
#(
   parameter int CNT_W = 20,
   parameter int BIT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_long,
   input  logic [CNT_W-1:0] len_short,
   input  logic [CNT_W-1:0] gap_len,
   input  logic [BIT_W-1:0] last_bit,
   input  logic             cpha,
   output logic             sck,
   output logic             pcs_en,
   output logic [BIT_W-1:0] bit_idx,
   output logic             busy,
   output logic             done
);
   tm_state_t        state;
   logic             seg;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len0_q, len1_q, gap_q;
   logic [BIT_W-1:0] last_q;
   logic             cpha_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         seg     <= 1'b0;
         cnt     <= '0;
         len0_q  <= '0;
         len1_q  <= '0;
         gap_q   <= '0;
         last_q  <= '0;
         cpha_q  <= 1'b0;
         bit_idx <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_BIT;
                  seg     <= 1'b0;
                  cnt     <= len_long - CNT_W'(1);
                  len0_q  <= len_long;
                  len1_q  <= len_short;
                  gap_q   <= gap_len;
                  last_q  <= last_bit;
                  cpha_q  <= cpha;
                  bit_idx <= '0;
               end
            end
            ST_BIT: begin
               if (cnt == '0) begin
                  if (!seg) begin
                     seg <= 1'b1;
                     cnt <= len1_q - CNT_W'(1);
                  end else if (bit_idx == last_q) begin
                     state   <= ST_GAP;
                     seg     <= 1'b0;
                     bit_idx <= '0;
                     cnt     <= gap_q - CNT_W'(2);
                  end else begin
                     seg     <= 1'b0;
                     bit_idx <= bit_idx + BIT_W'(1);
                     cnt     <= len0_q - CNT_W'(1);
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_GAP: begin
               if (cnt == '0) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pcs_en = (state == ST_BIT);
   assign sck    = pcs_en & (seg ^ cpha_q);
   assign busy   = (state != ST_IDLE);
   assign done   = done_q;

   assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (pcs_en && busy));

   assert_len_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |-> (len_short != '0 && len_long >= len_short && gap_len >= CNT_W'(2)));

   assert_sck_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pcs_en |-> (!sck && bit_idx == '0));

   assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_en |-> (bit_idx <= last_q));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(state) == ST_GAP && !busy));

   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pcs_en && start) |=> busy);

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
   import spi_tm_pkg::*;
#(
   parameter int CNT_W     = 20,
   parameter int BIT_W     = 4,
   parameter int SCL_W     = 4,
   parameter int DLY_W     = 4,
   parameter int MIN_FRAME = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       baud_pre,
   input  logic [SCL_W-1:0] baud_scl,
   input  logic             dbl_rate,
   input  logic             cpha,
   input  logic [1:0]       dly_pre,
   input  logic [DLY_W-1:0] dly_scl,
   input  logic [BIT_W-1:0] frame_code,
   input  logic             cont_mode,
   input  logic             cont_ovr,
   output logic             sck,
   output logic             pcs_en,
   output logic [BIT_W-1:0] bit_idx,
   output logic             busy,
   output logic             done
);
   localparam int NEED_CNT = (2 ** DLY_W) + 3;
   localparam logic [BIT_W-1:0] MIN_LAST = BIT_W'(MIN_FRAME - 1);

   if (CNT_W < NEED_CNT) begin : g_cnt_chk
      $error("CNT_W too narrow for the longest trailing delay");
   end
   if (MIN_FRAME < 2 || MIN_FRAME > 2 ** BIT_W) begin : g_frame_chk
      $error("MIN_FRAME out of range for BIT_W");
   end

   logic [CNT_W-1:0] period, len_long, len_short, gap_len;
   logic [BIT_W-1:0] last_bit;

   assign last_bit = (frame_code < MIN_LAST) ? MIN_LAST : frame_code;

   spi_tm_baud #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_baud (
      .baud_pre  (baud_pre),
      .baud_scl  (baud_scl),
      .dbl_rate  (dbl_rate),
      .period    (period),
      .len_long  (len_long),
      .len_short (len_short)
   );

   spi_tm_gap #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_gap (
      .dly_pre   (dly_pre),
      .dly_scl   (dly_scl),
      .cont_mode (cont_mode),
      .cont_ovr  (cont_ovr),
      .period    (period),
      .gap_len   (gap_len)
   );

   spi_tm_seq #(.CNT_W(CNT_W), .BIT_W(BIT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .len_long  (len_long),
      .len_short (len_short),
      .gap_len   (gap_len),
      .last_bit  (last_bit),
      .cpha      (cpha),
      .sck       (sck),
      .pcs_en    (pcs_en),
      .bit_idx   (bit_idx),
      .busy      (busy),
      .done      (done)
   );

endmodule

// File: tb/test_spi_sck_timer.sv
module test_spi_sck_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] baud_pre = '0;
   logic [3:0] baud_scl = '0;
   logic       dbl_rate = 1'b0;
   logic       cpha = 1'b0;
   logic [1:0] dly_pre = '0;
   logic [3:0] dly_scl = '0;
   logic [3:0] frame_code = '0;
   logic       cont_mode = 1'b0;
   logic       cont_ovr = 1'b0;
   logic       sck, pcs_en, busy, done;
   logic [3:0] bit_idx;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   spi_sck_timer i_spi_sck_timer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .baud_pre(baud_pre), .baud_scl(baud_scl), .dbl_rate(dbl_rate), .cpha(cpha),
      .dly_pre(dly_pre), .dly_scl(dly_scl), .frame_code(frame_code),
      .cont_mode(cont_mode), .cont_ovr(cont_ovr),
      .sck(sck), .pcs_en(pcs_en), .bit_idx(bit_idx), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int f_pre(input int c);
      case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
   endfunction
   function automatic int f_scl(input int c);
      return (c < 4) ? 2 * (c + 1) : (1 << c);
   endfunction
   function automatic int f_len(input int c);
      return (c < 3) ? 4 : c + 1;
   endfunction
   function automatic int f_per(input int p, input int s, input int d);
      return d ? (p * s) / 2 : p * s;
   endfunction
   function automatic int f_first(input int p, input int s, input int d);
      return d ? f_per(p, s, d) - (p / 2) * (s / 2) : (p * s) / 2;
   endfunction
   function automatic int f_gap(input int dp, input int ds, input int cm, input int ov, input int t);
      return (cm && !ov) ? t : (2 * dp + 1) * (1 << (ds + 1));
   endfunction

   // Issues start at the current negedge and returns at the negedge where done is high.
   task automatic run_frame(input int bp, input int bs, input int db, input int cp,
                            input int dp, input int ds, input int fc, input int cm,
                            input int ov, input bit disturb);
      int n, t, l0, d, p, g, sck_err, bit_err, busy_err, gap_err, first_bad, first_exp;
      string sreq;
      baud_pre = 2'(bp); baud_scl = 4'(bs); dbl_rate = 1'(db); cpha = 1'(cp);
      dly_pre = 2'(dp); dly_scl = 4'(ds); frame_code = 4'(fc);
      cont_mode = 1'(cm); cont_ovr = 1'(ov);
      n = f_len(fc); t = f_per(f_pre(bp), f_scl(bs), db);
      l0 = f_first(f_pre(bp), f_scl(bs), db); d = f_gap(dp, ds, cm, ov, t);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         baud_pre = 2'($urandom); baud_scl = 4'($urandom); dbl_rate = ~dbl_rate;
         cpha = ~cpha; dly_pre = 2'($urandom); dly_scl = 4'($urandom);
         frame_code = 4'($urandom); cont_mode = ~cont_mode;
      end
      p = 0; sck_err = 0; bit_err = 0; busy_err = 0; first_bad = -1; first_exp = 0;
      while (pcs_en && p < 70000) begin
         if (sck !== (((p % t) < l0) ? 1'(cp) : ~1'(cp))) begin
            sck_err++;
            if (first_bad < 0) begin first_bad = p; first_exp = ((p % t) < l0) ? cp : 1 - cp; end
         end
         if (int'(bit_idx) != p / t) bit_err++;
         if (!busy) busy_err++;
         if (disturb && p == 2) start = 1'b1;
         if (disturb && p == 3) start = 1'b0;
         p++;
         @(negedge clk);
      end
      sreq = cp ? "R6" : (db ? "R5" : "R4");
      chk(busy_err == 0, "R2", "busy low inside frame", busy_err, 0);
      chk(p == n * t, "R7", "pcs_en high cycles", p, n * t);
      chk(sck_err == 0, sreq, "sck waveform mismatches (first at cycle)", first_bad, first_exp);
      chk(bit_err == 0, "R7", "bit_idx mismatches", bit_err, 0);
      chk(t == f_per(f_pre(bp), f_scl(bs), db) && sck_err == 0, "R3", "sck period", sck_err, 0);
      if (disturb) begin
         chk(sck_err == 0 && p == n * t, "R11", "frame changed by mid-frame config", p, n * t);
         chk(p == n * t, "R10", "stray start altered frame", p, n * t);
      end
      g = 0; gap_err = 0;
      while (!done && g < 600000) begin
         if (pcs_en || sck || bit_idx != 0) gap_err++;
         g++;
         @(negedge clk);
      end
      chk(g == d - 1, (cm && !ov) ? "R9" : "R8", "low cycles before done", g, d - 1);
      chk(gap_err == 0 && !busy, "R1", "outputs quiet in gap/done", gap_err, 0);
   endtask

   task automatic after_done_idle;
      @(negedge clk);
      chk(done == 1'b0, "R8", "done width", int'(done), 0);
      chk(!pcs_en && !sck && !busy, "R1", "idle outputs", int'(pcs_en), 0);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      chk(!sck && !pcs_en && !busy && !done && bit_idx == 0, "R1", "reset outputs",
          int'({sck, pcs_en, busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sck && !pcs_en && !busy && !done, "R1", "after reset release",
          int'({sck, pcs_en, busy, done}), 0);

      // start pulse -> pcs_en next cycle
      start = 1'b1;
      @(posedge clk);
      #1;
      chk(pcs_en && busy, "R2", "pcs_en after start", int'(pcs_en), 1);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      after_done_idle();

      // every prescaler, both rates, both phases
      for (int bp = 0; bp < 4; bp++)
         for (int db = 0; db < 2; db++)
            for (int cp = 0; cp < 2; cp++)
               run_frame(bp, 1, db, cp, 0, 0, 3, 0, 0, 1'b0);
      after_done_idle();

      // reserved and maximum frame codes
      run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
      run_frame(1, 0, 1, 1, 1, 0, 2, 0, 0, 1'b0);
      run_frame(0, 0, 1, 0, 0, 0, 15, 0, 0, 1'b0);
      // larger scaler codes
      run_frame(3, 4, 1, 1, 0, 1, 4, 0, 0, 1'b0);
      run_frame(0, 5, 0, 0, 0, 0, 3, 0, 0, 1'b0);
      // back-to-back mode without and with override
      run_frame(2, 1, 1, 0, 3, 3, 5, 1, 0, 1'b0);
      run_frame(2, 1, 1, 0, 3, 3, 5, 1, 1, 1'b0);
      run_frame(1, 2, 0, 1, 2, 2, 6, 1, 0, 1'b0);
      after_done_idle();

      // random frames, some disturbed, mostly back-to-back
      for (int k = 0; k < 40; k++) begin
         run_frame(int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(1)),
                   int'($urandom_range(1)), int'($urandom_range(3)), int'($urandom_range(3)),
                   int'($urandom_range(15)), int'($urandom_range(1)), int'($urandom_range(1)),
                   1'($urandom_range(1)));
         if ($urandom_range(3) == 0) after_done_idle();
      end
      after_done_idle();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule